// File: doc/BRIEF.md
# CW Transmit/Receive Sequencer

This block turns a debounced Morse key level into the switching signals a transceiver needs when sending CW. Push-to-talk (`ptt`) and the receiver attenuator select (`rx_atten_en`) rise on the first clock edge that sees the key closed. The carrier gate (`rf_en`) is a copy of the key waveform shifted later by a programmable hold-off. Because every key edge is shifted by the same amount, each mark and each space keeps its length and the first character is not clipped. Once the last delayed mark has ended, `ptt` stays up for a programmable hang time, so relays in the path never switch while carrier is present.

Both delays are counted in pulses of `tick_ms`, a one-cycle strobe that arrives once per millisecond. Each delay is held in an 8-bit register that is loaded through its own write strobe. The hold-off resets to 20 ticks and the hang to 10 ticks. The sidetone enable is the key level itself, with no delay. The block handles key edges spaced at least the hold-off plus one tick apart.

Top module: `cw_tr_sequencer`

## Requirements
- R1: While `rst` is sampled high, `ptt`, `rf_en` and `rx_atten_en` go low on that edge, the hold-off reloads to 20 and the hang reloads to 10.
- R2: The first clock edge that samples `key_in` high sets `ptt`. `ptt` stays high on every edge that samples `key_in` high.
- R3: `tone_en` equals `key_in` at all times, combinationally.
- R4: With a nonzero hold-off N, `rf_en` rises on the edge that samples the Nth `tick_ms` pulse after the edge that first sees the key closed. A tick sampled on that key-edge cycle is not counted.
- R5: With a nonzero hold-off N, `rf_en` falls on the edge that samples the Nth tick after the edge that first sees the key open. Each mark on `rf_en` therefore lasts as many ticks as the key mark did.
- R6: With a hold-off of 0, `rf_en` takes the key level on the same edge that first samples the new key level.
- R7: The hang starts on the edge after `rf_en` falls with the key open. From the next edge on, ticks are counted. When U ticks have been counted, `ptt` falls on the following edge. With U = 0, `ptt` falls two edges after `rf_en` falls.
- R8: If the key closes while the hang is running, the hang is abandoned and `ptt` stays high with no low cycle.
- R9: `rf_en` is never high while `ptt` is low, and `ptt` never falls on an edge where `rf_en` was high.
- R10: A pulse on `holdoff_wr` loads `delay_val` into the hold-off, and a pulse on `hang_wr` loads it into the hang. The new value applies to key edges and hang starts on later clock edges.
- R11: `rx_atten_en` is high exactly when `ptt` is high, so it leads `rf_en` by the full hold-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-cycle strobe once per millisecond |
| key_in | input | 1 | Debounced key level, 1 = closed |
| holdoff_wr | input | 1 | Load `delay_val` into the key-down hold-off |
| hang_wr | input | 1 | Load `delay_val` into the key-up hang |
| delay_val | input | DLY_W | Delay value in ticks |
| ptt | output | 1 | Push-to-talk |
| rf_en | output | 1 | Carrier gate, delayed key |
| rx_atten_en | output | 1 | Receiver attenuator select for transmit |
| tone_en | output | 1 | Sidetone enable, undelayed key |

## Verification
A stale or mis-counted edge timer shows up on `rf_en` as a mark that starts or ends a tick early or late. This is visible on the first element after a delay change, within one hold-off. A hang counter that loads the wrong value or fails to clear shows up as `ptt` dropping early, possibly while carrier is still up, or never dropping at all. The bench predicts both outputs edge by edge from counted ticks. It compares them on every cycle, so any such fault is caught on the cycle it first appears.

// File: rtl/cw_tr_sequencer.sv
module cw_tr_sequencer #(
  parameter int DLY_W        = 8,
  parameter int HOLDOFF_INIT = 20,
  parameter int HANG_INIT    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             key_in,
  input  logic             holdoff_wr,
  input  logic             hang_wr,
  input  logic [DLY_W-1:0] delay_val,
  output logic             ptt,
  output logic             rf_en,
  output logic             rx_atten_en,
  output logic             tone_en
);

  localparam logic [DLY_W-1:0] HOLDOFF_RST = DLY_W'(HOLDOFF_INIT);
  localparam logic [DLY_W-1:0] HANG_RST    = DLY_W'(HANG_INIT);
  localparam logic [DLY_W-1:0] ONE         = DLY_W'(1);

  logic [DLY_W-1:0] holdoff, hang_len, edge_cnt, hang_cnt;
  logic key_q, pend, pend_lvl, hang_on, ptt_q, rf_q;

  wire key_edge   = key_in != key_q;
  wire hang_start = ptt_q & ~key_in & ~rf_q & ~pend & ~hang_on;

  assign ptt         = ptt_q;
  assign rx_atten_en = ptt_q;
  assign rf_en       = rf_q;
  assign tone_en     = key_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdoff  <= HOLDOFF_RST;
      hang_len <= HANG_RST;
    end else begin
      if (holdoff_wr) holdoff  <= delay_val;
      if (hang_wr)    hang_len <= delay_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q    <= 1'b0;
      pend     <= 1'b0;
      pend_lvl <= 1'b0;
      edge_cnt <= '0;
      rf_q     <= 1'b0;
    end else begin
      key_q <= key_in;
      if (key_edge) begin
        if (holdoff == '0) begin
          rf_q <= key_in;
          pend <= 1'b0;
        end else begin
          pend     <= 1'b1;
          pend_lvl <= key_in;
          edge_cnt <= holdoff;
        end
      end else if (pend && tick_ms) begin
        if (edge_cnt == ONE) begin
          rf_q <= pend_lvl;
          pend <= 1'b0;
        end else begin
          edge_cnt <= edge_cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptt_q    <= 1'b0;
      hang_on  <= 1'b0;
      hang_cnt <= '0;
    end else if (key_in) begin
      ptt_q   <= 1'b1;
      hang_on <= 1'b0;
    end else if (hang_start) begin
      hang_on  <= 1'b1;
      hang_cnt <= hang_len;
    end else if (hang_on) begin
      if (hang_cnt == '0) begin
        hang_on <= 1'b0;
        ptt_q   <= 1'b0;
      end else if (tick_ms) begin
        hang_cnt <= hang_cnt - ONE;
      end
    end
  end

  a_r9_rf_needs_ptt: assert property (@(posedge clk) disable iff (rst)
    rf_en |-> ptt);

  a_r9_no_drop_under_rf: assert property (@(posedge clk) disable iff (rst)
    $fell(ptt) |-> !$past(rf_en));

  a_r2_key_keys_ptt: assert property (@(posedge clk) disable iff (rst)
    key_in |=> ptt);

  a_r7_drop_only_key_open: assert property (@(posedge clk) disable iff (rst)
    $fell(ptt) |-> !$past(key_in));

  a_r4_rf_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    ($rose(rf_en) || $fell(rf_en)) |-> ($past(tick_ms) || $past(holdoff) == '0));

endmodule

// File: tb/cw_tr_sequencer_bench.sv
module cw_tr_sequencer_bench;
  localparam int TP    = 6;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_in = 1'b0;
  logic holdoff_wr = 1'b0;
  logic hang_wr = 1'b0;
  logic [7:0] delay_val = '0;
  logic ptt, rf_en, rx_atten_en, tone_en;
  logic tick_ms;
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit live = 0;
  bit r8_watch = 0;
  bit r8_gap = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= (cyc == TP - 1) ? 0 : cyc + 1;
  assign tick_ms = (cyc == TP - 1);

  cw_tr_sequencer u_cw_tr_sequencer (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .key_in(key_in),
    .holdoff_wr(holdoff_wr), .hang_wr(hang_wr), .delay_val(delay_val),
    .ptt(ptt), .rf_en(rf_en), .rx_atten_en(rx_atten_en), .tone_en(tone_en));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rf(int now_lvl, int old_lvl, int ticks, int dly);
    return (ticks >= dly) ? now_lvl : old_lvl;
  endfunction

  function automatic string rf_tag(int dly, int lvl);
    if (dly == 0) return "R6";
    return lvl ? "R4" : "R5";
  endfunction

  int kl, ko, tc, cap_d, dd, ud, cap_u, pm, rel, lc, ht, rf_m;

  always @(posedge clk) begin
    if (rst) begin
      kl = 0; ko = 0; tc = 0; cap_d = 20; dd = 20; ud = 10; cap_u = 10;
      pm = 0; rel = 0; lc = -1; ht = 0; rf_m = 0;
    end else begin
      if (int'(key_in) != kl) begin
        ko = kl; kl = int'(key_in); tc = 0; cap_d = dd;
      end else if (tick_ms && tc < 100000) tc++;
      rf_m = exp_rf(kl, ko, tc, cap_d);
      if (key_in) begin
        pm = 1; rel = 0; lc = -1;
      end else if (pm != 0) begin
        if (rel != 0) begin
          pm = 0; rel = 0; lc = -1;
        end else if (rf_m != 0) lc = -1;
        else if (lc < 0) begin
          lc = 0; ht = 0;
        end else begin
          lc++;
          if (lc == 1) cap_u = ud;
          if (lc >= 2 && tick_ms) ht++;
          if (ht >= cap_u) rel = 1;
        end
      end
      if (holdoff_wr) dd = int'(delay_val);
      if (hang_wr) ud = int'(delay_val);
    end
    #5;
    if (!rst && live) begin
      check(tone_en == key_in, "R3 tone", int'(tone_en), int'(key_in));
      check(int'(rf_en) == rf_m, rf_tag(cap_d, kl), int'(rf_en), rf_m);
      check(int'(ptt) == pm, kl ? "R2 ptt" : "R7 ptt", int'(ptt), pm);
      check(rx_atten_en == ptt, "R11 atten", int'(rx_atten_en), int'(ptt));
      check(!(rf_en && !ptt), "R9 rf without ptt", int'(rf_en), 0);
      if (r8_watch && !ptt) r8_gap = 1;
    end
  end

  task automatic set_key(input logic v);
    @(negedge clk);
    while (cyc == TP - 2) @(negedge clk);
    key_in = v;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TP) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (ptt || rf_en) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input int hold, input int hang);
    @(negedge clk);
    delay_val = 8'(hold); holdoff_wr = 1'b1;
    @(negedge clk);
    holdoff_wr = 1'b0; delay_val = 8'(hang); hang_wr = 1'b1;
    @(negedge clk);
    hang_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    live = 1;
    @(negedge clk);
    check(!ptt, "R1 reset ptt", int'(ptt), 0);
    check(!rf_en, "R1 reset rf", int'(rf_en), 0);
    check(!rx_atten_en, "R1 reset atten", int'(rx_atten_en), 0);

    // R1: default hold-off of 20 ticks
    set_key(1'b1);
    @(negedge clk);
    check(ptt && rx_atten_en, "R2 ptt at closure", int'(ptt), 1);
    check(rx_atten_en && !rf_en, "R11 atten before rf", int'(rf_en), 0);
    wait_ticks(18);
    check(!rf_en, "R1 default hold-off early", int'(rf_en), 0);
    wait_ticks(3);
    check(rf_en, "R1 default hold-off late", int'(rf_en), 1);
    wait_ticks(4);
    set_key(1'b0);
    wait_ticks(29);
    check(ptt, "R1 default hang still up", int'(ptt), 1);
    wait_idle();

    // R10 and R6: zero delays
    load(0, 0);
    set_key(1'b1);
    @(negedge clk);
    check(rf_en, "R6 zero hold-off", int'(rf_en), 1);
    wait_ticks(2);
    set_key(1'b0);
    @(negedge clk);
    check(!rf_en && ptt, "R6 zero hold-off release", int'(rf_en), 0);
    repeat (2) @(negedge clk);
    check(!ptt, "R7 zero hang", int'(ptt), 0);
    wait_idle();

    // R10: new hold-off of 4
    load(4, 3);
    set_key(1'b1);
    wait_ticks(3);
    check(!rf_en, "R10 hold-off 4 early", int'(rf_en), 0);
    wait_ticks(2);
    check(rf_en, "R10 hold-off 4 late", int'(rf_en), 1);
    set_key(1'b0);
    wait_idle();

    // R8: re-closure during the hang
    load(3, 8);
    set_key(1'b1);
    wait_ticks(6);
    set_key(1'b0);
    @(negedge clk);
    while (rf_en) @(negedge clk);
    r8_gap = 0; r8_watch = 1;
    wait_ticks(2);
    set_key(1'b1);
    wait_ticks(6);
    set_key(1'b0);
    @(negedge clk);
    while (rf_en) @(negedge clk);
    r8_watch = 0;
    check(!r8_gap, "R8 no ptt gap", int'(r8_gap), 0);
    wait_idle();

    // random traffic
    for (int it = 0; it < 40; it++) begin
      int hd, hg, n;
      hd = int'($urandom % 7);
      hg = int'($urandom % 9);
      n = 1 + int'($urandom % 4);
      load(hd, hg);
      for (int e = 0; e < n; e++) begin
        set_key(1'b1);
        wait_ticks(hd + 2 + int'($urandom % 6));
        set_key(1'b0);
        if (e != n - 1) wait_ticks(hd + 2 + int'($urandom % (hg + 4)));
      end
      wait_idle();
    end

    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule